// File: doc/BRIEF.md
# Receive DMA Channel (Peripheral to Memory)

This block moves a programmed number of bytes from a byte-wide peripheral into system memory. Software sets a destination address, a byte count and an access size through a small register-write port, then sets the enable bit. The channel requests bytes from the peripheral while its byte FIFO has room and still needs bytes. It packs the bytes it holds into 8-, 16- or 32-bit single writes on an AHB-style master port, and it honours wait states on that port.

When the data phase of the final write completes, the channel raises a sticky completion interrupt. If the peripheral drops its in-progress signal while a transfer is running, the channel stops requesting, finishes any bus write already issued, and discards the bytes that were not written. It then raises the interrupt together with an error flag. Two one-cycle markers show the start and the end of the stream: one when the first byte enters the FIFO, the other when the final byte leaves toward the bus.

Top module: `rx_dma_chan`

## Requirements
- R1: Register writes (`cfg_sel` 0 = destination address, 1 = byte count, 2 = control) take effect only while the channel is idle. A control write clears `irq_done` and `xfer_err`. Control bit 0 set, with a nonzero count, starts a transfer. No byte is requested and no bus write is made before such a start.
- R2: `pr_req` is high only while a transfer runs, the FIFO (depth 8 by default) is not full, and fewer bytes than the count have been taken. A byte is taken on each rising edge where `pr_req` and `pr_valid` are both high. With the bus stalled, exactly one FIFO depth of bytes is taken, and then `pr_req` falls.
- R3: `first_byte` pulses for one cycle, on the edge that stores the transfer's first byte.
- R4: Control bits [2:1] select the access size: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. A write of W bits is issued once W/8 bytes are in the FIFO. When fewer than W/8 bytes remain in the count, each remaining byte goes out as an 8-bit write.
- R5: Each write uses `htrans` = 2'b10 (NONSEQ), `hwrite` = 1 and `hsize` = 0/1/2 for 8/16/32 bits. The byte destined for address A travels on `hwdata[8*A[1:0] +: 8]`. The address starts at the destination and advances by the bytes written, so memory holds the bytes in arrival order.
- R6: While `hready` is low in an address phase, `haddr` and `htrans` hold. While `hready` is low in a data phase, `hwdata` holds.
- R7: `last_byte` pulses for one cycle, on the edge where the address phase carrying the final byte is accepted.
- R8: `irq_done` rises on the edge after `hready` completes the data phase of the final write, never earlier. It then stays high until a control write.
- R9: When `pr_busy` falls during a transfer, requests stop. Unwritten bytes are dropped, and once no write is in flight, `irq_done` and `xfer_err` both rise. A later start clears the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| pr_req | output | 1 | Byte request to the peripheral |
| pr_data | input | 8 | Peripheral byte |
| pr_valid | input | 1 | Peripheral byte valid |
| pr_busy | input | 1 | Peripheral in-progress |
| first_byte | output | 1 | First byte stored marker |
| last_byte | output | 1 | Final byte sent to bus marker |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Write indicator |
| hsize | output | 3 | Access size |
| hwdata | output | 32 | Write data |
| hready | input | 1 | Bus ready |
| irq_done | output | 1 | End-of-transfer interrupt |
| xfer_err | output | 1 | Abnormal end flag |

## Verification
A byte entering the FIFO from the peripheral and a group of bytes leaving it at bus address acceptance can land on the same clock edge, and the FIFO level must account for both. This is provoked by holding `pr_valid` high with zero-wait and random-wait bus responses in byte, halfword and word modes. The result is judged by rebuilding memory from the observed bus lanes and comparing every destination byte, and its untouched neighbours, against the expected arrival sequence. The abort path meets a bus write in flight the same way, and it is judged by requests staying low and by the interrupt and error flag rising together.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {BUS_IDLE, BUS_ADDR, BUS_DATA} bus_st_e;

  localparam logic [1:0] HT_IDLE   = 2'b00;
  localparam logic [1:0] HT_NONSEQ = 2'b10;

  localparam logic [1:0] SEL_DST  = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [7:0]                 din,
  input  logic                       pop,
  input  logic [2:0]                 pop_n,
  output logic [31:0]                peek,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW:0]   wp_q, rp_q, wp_n, rp_n;

  always_comb begin
    wp_n = wp_q;
    rp_n = rp_q;
    if (flush) begin
      wp_n = '0;
      rp_n = '0;
    end else begin
      if (push) wp_n = wp_q + PW'(1);
      if (pop)  rp_n = rp_q + PW'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_n;
      rp_q <= rp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q[AW-1:0]] <= din;
  end

  for (genvar k = 0; k < 4; k++) begin : g_peek
    assign peek[8*k +: 8] = mem[rp_q[AW-1:0] + AW'(k)];
  end

  assign level = wp_q - rp_q;
  assign full  = (level == PW'(DEPTH));

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));

  // R4
  pop_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (32'(pop_n) <= 32'(level)));
endmodule

// File: rtl/rxd_ahb_wr.sv
module rxd_ahb_wr
  import rxd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [31:0] iss_addr,
  input  logic [1:0]  iss_sz,
  input  logic [2:0]  iss_nb,
  input  logic [31:0] peek,
  input  logic        hready,
  output logic [31:0] haddr,
  output logic [1:0]  htrans,
  output logic        hwrite,
  output logic [2:0]  hsize,
  output logic [31:0] hwdata,
  output logic        accept,
  output logic        dphase_done,
  output logic [2:0]  dnb,
  output logic        idle
);
  bus_st_e     st_q, st_n;
  logic [31:0] a_q, wd_q, wd_n, mask;
  logic [1:0]  sz_q;
  logic [2:0]  nb_q;

  always_comb begin
    st_n        = st_q;
    accept      = 1'b0;
    dphase_done = 1'b0;
    case (st_q)
      BUS_IDLE: if (issue) st_n = BUS_ADDR;
      BUS_ADDR: if (hready) begin accept = 1'b1; st_n = BUS_DATA; end
      BUS_DATA: if (hready) begin dphase_done = 1'b1; st_n = BUS_IDLE; end
      default:  st_n = BUS_IDLE;
    endcase
    case (nb_q)
      3'd1:    mask = 32'h0000_00ff;
      3'd2:    mask = 32'h0000_ffff;
      default: mask = 32'hffff_ffff;
    endcase
    wd_n = (peek & mask) << {a_q[1:0], 3'b000};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BUS_IDLE;
      a_q  <= '0;
      sz_q <= '0;
      nb_q <= '0;
      wd_q <= '0;
    end else begin
      st_q <= st_n;
      if (st_q == BUS_IDLE && issue) begin
        a_q  <= iss_addr;
        sz_q <= iss_sz;
        nb_q <= iss_nb;
      end
      if (accept) wd_q <= wd_n;
    end
  end

  assign htrans = (st_q == BUS_ADDR) ? HT_NONSEQ : HT_IDLE;
  assign hwrite = (st_q == BUS_ADDR);
  assign haddr  = a_q;
  assign hsize  = {1'b0, sz_q};
  assign hwdata = wd_q;
  assign dnb    = nb_q;
  assign idle   = (st_q == BUS_IDLE);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == HT_NONSEQ && !hready) |=> (htrans == HT_NONSEQ && $stable(haddr) && $stable(hsize)));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BUS_DATA && !hready) |=> $stable(hwdata));

  // R5
  write_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == HT_NONSEQ) |-> (hwrite && hsize <= 3'd2));
endmodule

// File: rtl/rx_dma_chan.sv
module rx_dma_chan
  import rxd_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        pr_req,
  input  logic [7:0]  pr_data,
  input  logic        pr_valid,
  input  logic        pr_busy,
  output logic        first_byte,
  output logic        last_byte,
  output logic [31:0] haddr,
  output logic [1:0]  htrans,
  output logic        hwrite,
  output logic [2:0]  hsize,
  output logic [31:0] hwdata,
  input  logic        hready,
  output logic        irq_done,
  output logic        xfer_err
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]    rs_q;
  logic          srst_n;
  logic [31:0]   dst_q, dst_n, nxt_q, nxt_n;
  logic [CW-1:0] cnt_q, cnt_n, rx_q, rx_n, iss_q, iss_n, wr_q, wr_n, rem;
  logic [1:0]    szs_q, szs_n, iss_sz;
  logic          act_q, act_n, irq_q, irq_n, err_q, err_n, abt_q, abt_n, busy_q;
  logic          start, fin_abt, flush, push, issue, full, accept, dphase_done, bus_idle;
  logic [2:0]    nbw, want, dnb;
  logic [AW:0]   level;
  logic [31:0]   peek;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign push       = pr_req && pr_valid;
  assign pr_req     = act_q && !abt_q && !full && (rx_q != cnt_q);
  assign first_byte = push && (rx_q == '0);
  assign rem        = cnt_q - iss_q;
  assign nbw        = size_bytes(szs_q);
  assign want       = (rem >= CW'(nbw)) ? nbw : 3'd1;
  assign iss_sz     = (rem >= CW'(nbw)) ? szs_q : 2'd0;
  assign issue      = act_q && !abt_q && (rem != '0) && (32'(level) >= 32'(want));
  assign last_byte  = accept && ((iss_q + CW'(dnb)) == cnt_q);
  assign flush      = start || fin_abt;

  always_comb begin
    dst_n = dst_q;  cnt_n = cnt_q;  szs_n = szs_q;  nxt_n = nxt_q;
    act_n = act_q;  irq_n = irq_q;  err_n = err_q;  abt_n = abt_q;
    rx_n  = rx_q;   iss_n = iss_q;  wr_n  = wr_q;
    start = 1'b0;   fin_abt = 1'b0;
    if (cfg_we && !act_q) begin
      case (cfg_sel)
        SEL_DST: dst_n = cfg_wdata;
        SEL_CNT: cnt_n = cfg_wdata[CW-1:0];
        SEL_CTRL: begin
          szs_n = cfg_wdata[2] ? 2'd2 : cfg_wdata[2:1];
          irq_n = 1'b0;
          err_n = 1'b0;
          start = cfg_wdata[0] && (cnt_q != '0);
        end
        default: ;
      endcase
    end
    if (start) begin
      act_n = 1'b1; rx_n = '0; iss_n = '0; wr_n = '0; abt_n = 1'b0; nxt_n = dst_q;
    end
    if (push) rx_n = rx_q + CW'(1);
    if (accept) begin
      iss_n = iss_q + CW'(dnb);
      nxt_n = nxt_q + 32'(dnb);
    end
    if (dphase_done) begin
      wr_n = wr_q + CW'(dnb);
      if ((wr_q + CW'(dnb)) == cnt_q) begin
        act_n = 1'b0;
        irq_n = 1'b1;
      end
    end
    if (act_q && busy_q && !pr_busy) abt_n = 1'b1;
    if (abt_q && act_q && bus_idle) begin
      act_n = 1'b0; irq_n = 1'b1; err_n = 1'b1; abt_n = 1'b0; fin_abt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dst_q <= '0; cnt_q <= '0; szs_q <= '0; nxt_q <= '0;
      act_q <= 1'b0; irq_q <= 1'b0; err_q <= 1'b0; abt_q <= 1'b0; busy_q <= 1'b0;
      rx_q <= '0; iss_q <= '0; wr_q <= '0;
    end else begin
      dst_q <= dst_n; cnt_q <= cnt_n; szs_q <= szs_n; nxt_q <= nxt_n;
      act_q <= act_n; irq_q <= irq_n; err_q <= err_n; abt_q <= abt_n; busy_q <= pr_busy;
      rx_q <= rx_n; iss_q <= iss_n; wr_q <= wr_n;
    end
  end

  rxd_fifo #(.DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(srst_n), .flush(flush), .push(push), .din(pr_data),
    .pop(accept), .pop_n(dnb), .peek(peek), .level(level), .full(full)
  );

  rxd_ahb_wr bus_i (
    .clk(clk), .rst_n(srst_n), .issue(issue), .iss_addr(nxt_q), .iss_sz(iss_sz),
    .iss_nb(want), .peek(peek), .hready(hready), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .accept(accept),
    .dphase_done(dphase_done), .dnb(dnb), .idle(bus_idle)
  );

  assign irq_done = irq_q;
  assign xfer_err = err_q;

  // R8
  irq_after_data_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ($rose(irq_done) && !xfer_err) |-> $past(dphase_done));

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    xfer_err |-> (!pr_req && htrans == HT_IDLE));

  // R3
  first_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    first_byte |=> !first_byte);

  // R7
  last_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    last_byte |=> !last_byte);
endmodule

// File: tb/rx_dma_chan_tb.sv
module rx_dma_chan_tb_top;
  localparam int CLK_P  = 10;
  localparam int FIFO_D = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        pr_req, pr_valid, pr_busy, first_byte, last_byte;
  logic [7:0]  pr_data;
  logic [31:0] haddr, hwdata;
  logic [1:0]  htrans;
  logic        hwrite, hready, irq_done, xfer_err;
  logic [2:0]  hsize;

  rx_dma_chan #(.DEPTH(FIFO_D), .CW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pr_req(pr_req), .pr_data(pr_data), .pr_valid(pr_valid), .pr_busy(pr_busy),
    .first_byte(first_byte), .last_byte(last_byte), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .irq_done(irq_done), .xfer_err(xfer_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mem [64];
  logic [15:0] lfsr = 16'hace1;
  logic wmode = 1'b0, vmode = 1'b0, force_low = 1'b0, armed = 1'b0;
  logic [7:0] base = 8'h00;
  int sent_cnt, wr_bytes, n8, n16, n32, first_cnt, first_ok, last_cnt, last_ok;
  int stall_viol, irq_early, exp_cnt, exp_end;
  logic dp_pend = 1'b0, prev_stall = 1'b0;
  logic [31:0] pend_addr, prev_addr;
  logic [2:0] pend_size;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hready   = force_low ? 1'b0 : (wmode ? (lfsr[3] | lfsr[5]) : 1'b1);
    pr_valid = vmode ? lfsr[0] : 1'b1;
    pr_data  = base + 8'(sent_cnt);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (armed && irq_done && !xfer_err && wr_bytes != exp_cnt) irq_early++;
    if (prev_stall && (htrans != 2'b10 || haddr != prev_addr)) stall_viol++;
    prev_stall = (htrans == 2'b10) && !hready;
    prev_addr  = haddr;
    if (first_byte) begin
      first_cnt++;
      if (pr_req && pr_valid && sent_cnt == 0) first_ok++;
    end
    if (pr_req && pr_valid) sent_cnt++;
    if (dp_pend && hready) begin
      for (int b = 0; b < (1 << pend_size); b++) begin
        logic [31:0] a;
        a = pend_addr + 32'(b);
        mem[a[5:0]] = hwdata[8*a[1:0] +: 8];
      end
      wr_bytes += (1 << pend_size);
      dp_pend = 1'b0;
    end
    if (htrans == 2'b10 && hready) begin
      pend_addr = haddr; pend_size = hsize; dp_pend = 1'b1;
      case (hsize) 3'd0: n8++; 3'd1: n16++; default: n32++; endcase
      if (last_byte) begin
        last_cnt++;
        if (haddr + (32'd1 << hsize) == 32'(exp_end)) last_ok++;
      end
    end else if (last_byte) last_cnt++;
  end

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_stats(input int addr, input int cnt);
    for (int i = 0; i < 64; i++) mem[i] = 8'hee;
    sent_cnt = 0; wr_bytes = 0; n8 = 0; n16 = 0; n32 = 0;
    first_cnt = 0; first_ok = 0; last_cnt = 0; last_ok = 0;
    exp_cnt = cnt; exp_end = addr + cnt;
  endtask

  task automatic start_xfer(input int addr, input int cnt, input int sz);
    clear_stats(addr, cnt);
    cfg_write(2'd0, 32'(addr));
    cfg_write(2'd1, 32'(cnt));
    cfg_write(2'd2, {29'd0, 2'(sz), 1'b1});
    armed = 1'b1;
  endtask

  task automatic wait_irq(input int limit);
    for (int i = 0; i < limit && !irq_done; i++) @(negedge clk);
  endtask

  task automatic check_done(input string tag, input int addr, input int cnt,
                            input int e8, input int e16, input int e32);
    int bad = 0;
    chk(irq_done === 1'b1, {tag, " R8 irq"}, int'(irq_done), 1);
    chk(xfer_err === 1'b0, {tag, " R9 err"}, int'(xfer_err), 0);
    for (int i = 0; i < cnt; i++) if (mem[addr + i] !== base + 8'(i)) bad++;
    chk(bad == 0, {tag, " R5 data"}, bad, 0);
    if (addr > 0) chk(mem[addr-1] === 8'hee, {tag, " R5 guard low"}, int'(mem[addr-1]), 'hee);
    if (addr + cnt < 64) chk(mem[addr+cnt] === 8'hee, {tag, " R5 guard high"}, int'(mem[addr+cnt]), 'hee);
    chk(sent_cnt == cnt, {tag, " R2 taken"}, sent_cnt, cnt);
    chk(n8 == e8 && n16 == e16 && n32 == e32, {tag, " R4 sizes"}, n8*100 + n16*10 + n32, e8*100 + e16*10 + e32);
    chk(first_cnt == 1 && first_ok == 1, {tag, " R3 first"}, first_cnt*10 + first_ok, 11);
    chk(last_cnt == 1 && last_ok == 1, {tag, " R7 last"}, last_cnt*10 + last_ok, 11);
    chk(irq_early == 0, {tag, " R8 early"}, irq_early, 0);
    chk(stall_viol == 0, {tag, " R6 hold"}, stall_viol, 0);
    armed = 1'b0;
  endtask

  task automatic run_xfer(input string tag, input int addr, input int cnt, input int sz,
                          input logic [7:0] b, input logic wm, input logic vm,
                          input int e8, input int e16, input int e32);
    base = b; wmode = wm; vmode = vm;
    start_xfer(addr, cnt, sz);
    wait_irq(3000);
    repeat (2) @(negedge clk);
    check_done(tag, addr, cnt, e8, e16, e32);
  endtask

  task automatic t_reset();
    chk(htrans == 2'b00, "R5 reset htrans", int'(htrans), 0);
    chk(pr_req == 1'b0, "R2 reset req", int'(pr_req), 0);
    chk(irq_done == 1'b0 && xfer_err == 1'b0, "R1 reset flags", int'({irq_done, xfer_err}), 0);
  endtask

  task automatic t_no_enable();
    int req_seen = 0, bus_seen = 0;
    clear_stats(0, 0);
    cfg_write(2'd0, 32'd4);
    cfg_write(2'd1, 32'd4);
    cfg_write(2'd2, 32'd4);
    repeat (20) begin
      @(negedge clk);
      if (pr_req) req_seen++;
      if (htrans != 2'b00) bus_seen++;
    end
    chk(req_seen == 0 && sent_cnt == 0, "R1 no start without enable", req_seen + sent_cnt, 0);
    chk(bus_seen == 0, "R1 no bus without enable", bus_seen, 0);
  endtask

  task automatic t_stall_full();
    int req_hi;
    force_low = 1'b1; base = 8'h80; wmode = 1'b0; vmode = 1'b0;
    start_xfer(40, 16, 2);
    repeat (40) @(negedge clk);
    req_hi = int'(pr_req);
    chk(sent_cnt == FIFO_D, "R2 fills to depth", sent_cnt, FIFO_D);
    chk(req_hi == 0, "R2 req low when full", req_hi, 0);
    force_low = 1'b0;
    wait_irq(3000);
    repeat (2) @(negedge clk);
    check_done("stall", 40, 16, 0, 0, 4);
  endtask

  task automatic t_clear_irq();
    cfg_write(2'd2, 32'd0);
    chk(irq_done == 1'b0, "R1 control write clears irq", int'(irq_done), 0);
  endtask

  task automatic t_abort();
    int quiet = 0, snap;
    base = 8'h40; wmode = 1'b1; vmode = 1'b1;
    start_xfer(0, 16, 2);
    armed = 1'b0;
    for (int i = 0; i < 2000 && sent_cnt < 5; i++) @(negedge clk);
    pr_busy = 1'b0;
    wait_irq(200);
    repeat (2) @(negedge clk);
    chk(irq_done === 1'b1 && xfer_err === 1'b1, "R9 irq and err", int'({irq_done, xfer_err}), 3);
    snap = sent_cnt;
    repeat (20) begin
      @(negedge clk);
      if (pr_req || htrans != 2'b00) quiet++;
    end
    chk(quiet == 0 && sent_cnt == snap, "R9 stopped", quiet, 0);
    chk(wr_bytes <= snap && wr_bytes < 16, "R9 partial writes", wr_bytes, snap);
    pr_busy = 1'b1;
    @(negedge clk);
    cfg_write(2'd2, 32'd0);
    chk(irq_done == 1'b0 && xfer_err == 1'b0, "R9 flags cleared", int'({irq_done, xfer_err}), 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0;
    pr_busy = 1'b1; hready = 1'b1; pr_valid = 1'b0; pr_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_enable();
    run_xfer("word", 8, 8, 2, 8'h10, 1'b0, 1'b0, 0, 0, 2);
    t_clear_irq();
    run_xfer("half", 16, 6, 1, 8'h20, 1'b1, 1'b1, 0, 3, 0);
    run_xfer("byte", 3, 5, 0, 8'h30, 1'b0, 1'b0, 5, 0, 0);
    run_xfer("tail", 32, 7, 2, 8'h50, 1'b1, 1'b0, 3, 0, 1);
    run_xfer("size3", 20, 8, 3, 8'h60, 1'b0, 1'b1, 0, 0, 2);
    t_stall_full();
    t_abort();
    run_xfer("recover", 12, 12, 1, 8'h70, 1'b1, 1'b1, 0, 6, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule